// File: doc/BRIEF.md
# Shared-Bus Value Resolver

This block computes the value a shared line takes when several drivers may put a bit on it at once. Each driver has an enable and a data bit. A driver with its enable low is disconnected. A driver with its enable high drives its data bit. The block merges all contributions into one four-valued result, carried as a 2-bit code so that the logic stays synthesizable: `00` is logic 0, `01` is logic 1, `10` is high impedance, and `11` is unknown.

The block also counts the drivers that are currently enabled. It raises a collision flag whenever the one-driver-at-a-time rule is broken. A system-level checker or arbiter uses the result to catch bad bus sharing. The flag is raised even when the colliding drivers agree on the value, so a latent arbitration fault shows up before it corrupts data. The logic is purely combinational, and the number of drivers is a parameter.

Top module: `bus_resolver`

## Requirements
- R1: With no driver enabled, `bus_val` is `2'b10` (high impedance), `act_cnt` is 0 and `collide` is 0.
- R2: With exactly one driver enabled, `bus_val` is `2'b00` when that driver's data bit is 0 and `2'b01` when it is 1.
- R3: When at least one enabled driver drives 0 and at least one enabled driver drives 1, `bus_val` is `2'b11` (unknown), however many other drivers are enabled.
- R4: When two or more drivers are enabled and all of them drive the same bit, `bus_val` is that bit (`2'b00` or `2'b01`), not unknown.
- R5: `act_cnt` equals the number of set bits in `drv_en`, over the full range 0 to N.
- R6: `collide` is 1 exactly when two or more drivers are enabled, whether or not their data bits agree.
- R7: The data bit of a disabled driver has no effect on any output.
- R8: The outputs do not depend on which driver positions hold a given set of (enable, data) pairs. Any permutation of the drivers gives the same `bus_val`, `act_cnt` and `collide`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_en | input | N | Per-driver enable; 1 connects the driver to the bus |
| drv_dat | input | N | Per-driver data bit, used only while enabled |
| bus_val | output | 2 | Resolved bus value: 00 = 0, 01 = 1, 10 = Z, 11 = X |
| act_cnt | output | $clog2(N+1) | Number of enabled drivers |
| collide | output | 1 | Set when more than one driver is enabled |

## Verification
Value resolution and collision detection both react to the same event: two or more enabled drivers. They must agree when the drivers disagree (unknown value, flag high) and also when the drivers agree (a clean 0 or 1, with the flag still high). The bench walks every combination of enables and data bits for the default width. It compares each result against a behavioural model that only counts enabled zeros and ones. It then replays each pattern reversed and rotated, and with the data bits of idle drivers flipped. The outputs must stay unchanged under all three variations.

// File: rtl/bus_res_pkg.sv
package bus_res_pkg;

    typedef enum logic [1:0] {
        LV_0 = 2'b00,
        LV_1 = 2'b01,
        LV_Z = 2'b10,
        LV_X = 2'b11
    } lvl_e;

    // Merge two contributions on one line; commutative and associative.
    function automatic lvl_e merge_lvl(lvl_e a, lvl_e b);
        if (a == LV_X || b == LV_X) return LV_X;
        if (a == LV_Z) return b;
        if (b == LV_Z) return a;
        if (a == b) return a;
        return LV_X;
    endfunction

    function automatic lvl_e drive_lvl(logic en, logic d);
        if (!en) return LV_Z;
        return d ? LV_1 : LV_0;
    endfunction

    function automatic int cnt_width(int n);
        return $clog2(n + 1);
    endfunction

    function automatic int tree_levels(int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

endpackage

// File: rtl/drv_encode.sv
module drv_encode
    import bus_res_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] en,
    input  logic [N-1:0] dat,
    output lvl_e         lvl [N]
);
    for (genvar i = 0; i < N; i++) begin : g_drv
        assign lvl[i] = drive_lvl(en[i], dat[i]);
    end
endmodule

// File: rtl/lvl_tree.sv
module lvl_tree
    import bus_res_pkg::*;
#(
    parameter int N = 4
) (
    input  lvl_e lvl [N],
    output lvl_e res
);
    localparam int LEVELS = tree_levels(N);
    localparam int PAD    = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : lv
        localparam int W = PAD >> l;
        lvl_e v [W];
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < W; k++) begin : g_k
                if (k < N) begin : g_real
                    assign v[k] = lvl[k];
                end else begin : g_pad
                    assign v[k] = LV_Z;
                end
            end
        end else begin : g_node
            for (genvar k = 0; k < W; k++) begin : g_k
                assign v[k] = merge_lvl(lv[l-1].v[2*k], lv[l-1].v[2*k+1]);
            end
        end
    end

    assign res = lv[LEVELS].v[0];
endmodule

// File: rtl/act_count.sv
module act_count
    import bus_res_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = cnt_width(N)
) (
    input  logic [N-1:0]  en,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(en[i]);
        end
    end
endmodule

// File: rtl/multi_detect.sv
module multi_detect #(
    parameter int N = 4
) (
    input  logic [N-1:0] en,
    output logic         multi
);
    localparam logic [N-1:0] ONE = N'(1);
    // Clearing the lowest set bit leaves something only if two or more were set.
    assign multi = |(en & (en - ONE));
endmodule

// File: rtl/bus_resolver.sv
module bus_resolver
    import bus_res_pkg::*;
#(
    parameter  int N  = 4,
    localparam int CW = cnt_width(N)
) (
    input  logic [N-1:0]  drv_en,
    input  logic [N-1:0]  drv_dat,
    output logic [1:0]    bus_val,
    output logic [CW-1:0] act_cnt,
    output logic          collide
);
    lvl_e drv_lvl [N];
    lvl_e res_lvl;

    drv_encode #(.N(N)) u_enc (
        .en  (drv_en),
        .dat (drv_dat),
        .lvl (drv_lvl)
    );

    lvl_tree #(.N(N)) u_tree (
        .lvl (drv_lvl),
        .res (res_lvl)
    );

    act_count #(.N(N), .CW(CW)) u_cnt (
        .en  (drv_en),
        .cnt (act_cnt)
    );

    multi_detect #(.N(N)) u_multi (
        .en    (drv_en),
        .multi (collide)
    );

    assign bus_val = res_lvl;

    always_comb begin
        // R1
        idle_z_chk: assert ((act_cnt != '0) || (res_lvl == LV_Z));
        // R2
        single_known_chk: assert ((act_cnt != CW'(1)) || (res_lvl == LV_0) || (res_lvl == LV_1));
        // R3
        x_needs_many_chk: assert ((res_lvl != LV_X) || collide);
        // R6
        collide_cnt_chk: assert (collide == (act_cnt > CW'(1)));
        // R1
        z_means_idle_chk: assert ((res_lvl != LV_Z) || (act_cnt == '0));
    end
endmodule

// File: tb/tb_bus_resolver.sv
module tb_bus_resolver;
    localparam int N  = 4;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [N-1:0]  drv_en;
    logic [N-1:0]  drv_dat;
    logic [1:0]    bus_val;
    logic [CW-1:0] act_cnt;
    logic          collide;

    bus_resolver #(.N(N)) dut (
        .drv_en  (drv_en),
        .drv_dat (drv_dat),
        .bus_val (bus_val),
        .act_cnt (act_cnt),
        .collide (collide)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] e, input logic [N-1:0] d);
        @(posedge clk);
        drv_en  <= rst ? '0 : e;
        drv_dat <= d;
        @(negedge clk);
    endtask

    function automatic int ref_val(input logic [N-1:0] e, input logic [N-1:0] d);
        int ones = 0;
        int zeros = 0;
        for (int i = 0; i < N; i++) begin
            if (e[i] && d[i]) ones++;
            if (e[i] && !d[i]) zeros++;
        end
        if (ones > 0 && zeros > 0) return 3;
        if (ones > 0) return 1;
        if (zeros > 0) return 0;
        return 2;
    endfunction

    function automatic logic [N-1:0] rev(input logic [N-1:0] x);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = x[N-1-i];
        return r;
    endfunction

    function automatic logic [N-1:0] rot(input logic [N-1:0] x);
        return {x[N-2:0], x[N-1]};
    endfunction

    initial begin
        drv_en  = '0;
        drv_dat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset/idle state
        chk(bus_val == 2'b10, "R1 idle value", bus_val, 2);
        chk(act_cnt == 0, "R1 idle count", act_cnt, 0);
        chk(collide == 0, "R1 idle flag", collide, 0);
        rst = 1'b0;

        for (int e = 0; e < (1 << N); e++) begin
            for (int d = 0; d < (1 << N); d++) begin
                logic [N-1:0] ev;
                logic [N-1:0] dv;
                int pc;
                int xv;
                logic [1:0] b0;
                logic [CW-1:0] c0;
                logic f0;
                ev = N'(e);
                dv = N'(d);
                pc = $countones(ev);
                xv = ref_val(ev, dv);
                apply(ev, dv);
                b0 = bus_val; c0 = act_cnt; f0 = collide;
                if (pc == 0)
                    chk(bus_val == 2'(xv), "R1 all idle gives Z", bus_val, xv);
                else if (pc == 1)
                    chk(bus_val == 2'(xv), "R2 single driver value", bus_val, xv);
                else if (xv == 3)
                    chk(bus_val == 2'(xv), "R3 conflict gives X", bus_val, xv);
                else
                    chk(bus_val == 2'(xv), "R4 agreeing drivers", bus_val, xv);
                chk(act_cnt == CW'(pc), "R5 active count", act_cnt, pc);
                chk(collide == (pc > 1), "R6 collision flag", collide, int'(pc > 1));

                // R8: reversed driver order
                apply(rev(ev), rev(dv));
                chk(bus_val == b0 && act_cnt == c0 && collide == f0,
                    "R8 reversed order", {bus_val, act_cnt, collide}, {b0, c0, f0});
                // R8: rotated driver order
                apply(rot(ev), rot(dv));
                chk(bus_val == b0 && act_cnt == c0 && collide == f0,
                    "R8 rotated order", {bus_val, act_cnt, collide}, {b0, c0, f0});
                // R7: flip data of disabled drivers
                apply(ev, dv ^ ~ev);
                chk(bus_val == b0 && act_cnt == c0 && collide == f0,
                    "R7 idle data ignored", {bus_val, act_cnt, collide}, {b0, c0, f0});
            end
        end

        // R3: X persists with every driver on and one dissenter
        apply('1, N'(1));
        chk(bus_val == 2'b11, "R3 one dissenter among all", bus_val, 3);
        // R4 and R6: all drivers agree on 1
        apply('1, '1);
        chk(bus_val == 2'b01, "R4 all agree on one", bus_val, 1);
        chk(collide == 1'b1, "R6 flag on agreeing drivers", collide, 1);
        chk(act_cnt == CW'(N), "R5 full count", act_cnt, N);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule